// File: doc/BRIEF.md
# Warm-reboot command sequencer

This block takes a single start pulse and plays out, word by word, the fixed command stream that makes an FPGA configuration port reboot itself into a chosen bitstream. It emits a dummy word, the two synchronisation words and four one-word register writes. Those writes place a primary boot address and a fallback boot address into general-purpose registers. The stream closes with a reboot command and a trailing no-op. The address and opcode inputs are latched when the run starts, so the caller may change them freely afterwards.

Each word is presented on a 16-bit data bus with a valid strobe. The word is held until the downstream port takes it, which happens on a cycle where the port does not raise stall. Before a word leaves the block, the bit order inside each of its bytes is mirrored, because that is the orientation the configuration port expects. A `busy` flag covers the whole run. A one-cycle `done` pulse marks a complete run. If the port stalls one word for too long, a watchdog drops the run quietly and the block returns to idle.

Top module: `warmboot_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `cfg_valid`, `busy` and `done` are low.
- R2: A `start` pulse seen while idle makes `cfg_valid` and `busy` high on the next cycle, and the first word presented is 0xFFFF.
- R3: Before byte mirroring, the run presents exactly 14 words in this order: FFFF, AA99, 5566, 3261, P_lo, 3281, P_hi, 32A1, F_lo, 32C1, F_hi, 30A1, 000E, 2000.
- R4: Every register-write header has the form {3'b001, 2'b10, 6-bit register number, 5'd1}. The registers are 0x13, 0x14, 0x15 and 0x16 for the four general registers, and 0x05 for the command register. The no-op word is 0x2000.
- R5: P_lo and F_lo carry bits [15:0] of the primary and fallback addresses. P_hi and F_hi carry the opcode in bits [15:8] and address bits [23:16] in bits [7:0].
- R6: Within each byte of every emitted word, bit i of the sequence word appears at bit 7-i of `cfg_data`. For example, header 0x3261 leaves the block as 0x4C86.
- R7: The run moves to the next word only on a cycle where `cfg_valid` is high and `cfg_stall` is low. While stalled, `cfg_data` stays unchanged.
- R8: The addresses and the opcode are captured on the accepted start pulse. Changes to those inputs during a run do not alter the words emitted.
- R9: A `start` pulse received while `busy` is high has no effect on the word stream or on the run length.
- R10: On the cycle after the final no-op is accepted, `done` is high for exactly one cycle, while `busy` and `cfg_valid` are already low.
- R11: If 4096 consecutive busy cycles pass without an accepted word, the block returns to idle on the next cycle without raising `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch pulse |
| mb_addr | input | 24 | Primary boot start address |
| fb_addr | input | 24 | Fallback boot start address |
| boot_op | input | 8 | Opcode placed in both high-address words |
| cfg_stall | input | 1 | Downstream port cannot take a word this cycle |
| cfg_valid | output | 1 | `cfg_data` holds a word to be taken |
| cfg_data | output | 16 | Byte-mirrored configuration word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after a complete run |

## Verification
The bench aims at the edges of the handshake. Under random stall, a design that advanced on stall would skip words, and one that recomputed the word from live inputs would show changed addresses in the middle of a run. A start pulse in the middle of a run would restart a careless design and lengthen the run. The sink is held stalled for more than 4096 cycles to show that the watchdog drops the run with no `done`. That test also confirms the block launches cleanly afterwards. Explicit literal checks of the mirrored header and the address words catch a design that reverses whole words instead of bytes, or that swaps the opcode and address fields.

// File: rtl/warmboot_pkg.sv
package warmboot_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 24;
  localparam int OP_W    = 8;
  localparam int SEQ_LEN = 14;
  localparam int IDX_W   = $clog2(SEQ_LEN);

  localparam logic [5:0] REG_CMD  = 6'h05;
  localparam logic [5:0] REG_GEN1 = 6'h13;
  localparam logic [5:0] REG_GEN2 = 6'h14;
  localparam logic [5:0] REG_GEN3 = 6'h15;
  localparam logic [5:0] REG_GEN4 = 6'h16;

  localparam logic [WORD_W-1:0] W_DUMMY  = 16'hFFFF;
  localparam logic [WORD_W-1:0] W_SYNC0  = 16'hAA99;
  localparam logic [WORD_W-1:0] W_SYNC1  = 16'h5566;
  localparam logic [WORD_W-1:0] W_NOOP   = 16'h2000;
  localparam logic [WORD_W-1:0] W_REBOOT = 16'h000E;

  // Single-word register write header.
  function automatic logic [WORD_W-1:0] wr1_header(input logic [5:0] regnum);
    return {3'b001, 2'b10, regnum, 5'd1};
  endfunction

  // Unmirrored word at a given step of the run.
  function automatic logic [WORD_W-1:0] seq_word(
    input logic [IDX_W-1:0]  idx,
    input logic [ADDR_W-1:0] prim,
    input logic [ADDR_W-1:0] fall,
    input logic [OP_W-1:0]   op);
    logic [WORD_W-1:0] w;
    case (idx)
      4'd0:    w = W_DUMMY;
      4'd1:    w = W_SYNC0;
      4'd2:    w = W_SYNC1;
      4'd3:    w = wr1_header(REG_GEN1);
      4'd4:    w = prim[15:0];
      4'd5:    w = wr1_header(REG_GEN2);
      4'd6:    w = {op, prim[23:16]};
      4'd7:    w = wr1_header(REG_GEN3);
      4'd8:    w = fall[15:0];
      4'd9:    w = wr1_header(REG_GEN4);
      4'd10:   w = {op, fall[23:16]};
      4'd11:   w = wr1_header(REG_CMD);
      4'd12:   w = W_REBOOT;
      default: w = W_NOOP;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/wb_word_gen.sv
module wb_word_gen
  import warmboot_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] prim,
  input  logic [ADDR_W-1:0] fall,
  input  logic [OP_W-1:0]   op,
  output logic [WORD_W-1:0] word_out
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] raw;
  assign raw = seq_word(idx, prim, fall, op);

  // Mirror bit order inside each byte.
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign word_out[8*b + 7 - i] = raw[8*b + i];
    end
  end
endmodule

// File: rtl/wb_step_ctr.sv
module wb_step_ctr #(
  parameter int LEN = 14,
  localparam int IW = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          advance,
  input  logic          abort,
  output logic [IW-1:0] idx,
  output logic          active,
  output logic          finish
);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  logic at_last;
  assign at_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      finish <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (!active) begin
        if (launch) begin
          active <= 1'b1;
          idx    <= '0;
        end
      end else if (advance) begin
        if (at_last) begin
          active <= 1'b0;
          finish <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (abort) begin
        active <= 1'b0;
      end
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    finish |=> !finish);
  assert_idx_steps_R7: assert property (@(posedge clk) disable iff (rst)
    active && !advance |=> $stable(idx));
endmodule

// File: rtl/wb_stall_watchdog.sv
module wb_stall_watchdog #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic accept,
  output logic expire
);
  logic [CNT_W-1:0] cnt;
  logic             sat;

  assign sat    = &cnt;
  assign expire = active && !accept && sat;

  always_ff @(posedge clk) begin
    if (rst || !active || accept) cnt <= '0;
    else if (!sat)                cnt <= cnt + 1'b1;
  end

  assert_wd_clear_R11: assert property (@(posedge clk) disable iff (rst)
    accept |=> cnt == '0);
endmodule

// File: rtl/warmboot_seq.sv
module warmboot_seq
  import warmboot_pkg::*;
#(
  parameter int WD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] mb_addr,
  input  logic [ADDR_W-1:0] fb_addr,
  input  logic [OP_W-1:0]   boot_op,
  input  logic              cfg_stall,
  output logic              cfg_valid,
  output logic [WORD_W-1:0] cfg_data,
  output logic              busy,
  output logic              done
);
  logic [ADDR_W-1:0] mb_q, fb_q;
  logic [OP_W-1:0]   op_q;
  logic [IDX_W-1:0]  idx;
  logic              active, launch_w, accept_w, abort_w;

  assign launch_w = start && !active;
  assign accept_w = active && !cfg_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      mb_q <= '0;
      fb_q <= '0;
      op_q <= '0;
    end else if (launch_w) begin
      mb_q <= mb_addr;
      fb_q <= fb_addr;
      op_q <= boot_op;
    end
  end

  wb_step_ctr #(.LEN(SEQ_LEN)) u_step (
    .clk(clk), .rst(rst), .launch(launch_w), .advance(accept_w),
    .abort(abort_w), .idx(idx), .active(active), .finish(done));

  wb_stall_watchdog #(.CNT_W(WD_W)) u_wd (
    .clk(clk), .rst(rst), .active(active), .accept(accept_w),
    .expire(abort_w));

  wb_word_gen u_gen (
    .idx(idx), .prim(mb_q), .fall(fb_q), .op(op_q), .word_out(cfg_data));

  assign cfg_valid = active;
  assign busy      = active;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cfg_valid && !$isunknown(cfg_valid));
  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && cfg_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && cfg_stall && !abort_w |=> cfg_valid && $stable(cfg_data));
  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mb_q) && $stable(fb_q) && $stable(op_q));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    busy && cfg_stall && !abort_w |=> busy);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !cfg_valid);
  assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    abort_w |=> !busy && !done);
endmodule

// File: tb/warmboot_seq_test.sv
`timescale 1ns/1ps
module warmboot_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] mb_addr = '0, fb_addr = '0;
  logic [7:0]  boot_op = '0;
  logic        cfg_stall = 1'b0;
  logic        cfg_valid, busy, done;
  logic [15:0] cfg_data;

  int checks = 0, fails = 0;
  int stall_mode = 0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  warmboot_seq uut (
    .clk(clk), .rst(rst), .start(start), .mb_addr(mb_addr), .fb_addr(fb_addr),
    .boot_op(boot_op), .cfg_stall(cfg_stall), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data), .busy(busy), .done(done));

  // Reference model
  bit m_busy = 0, m_done = 0;
  int m_pos = 0, m_wd = 0;
  logic [15:0] m_q[$];

  function automatic logic [15:0] mirror(input logic [15:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[(i / 8) * 8 + 7 - (i % 8)] = w[i];
    return r;
  endfunction

  task automatic build(input logic [23:0] p, input logic [23:0] f, input logic [7:0] o);
    logic [15:0] lst[$];
    lst = '{16'hFFFF, 16'hAA99, 16'h5566, 16'h3261, p[15:0], 16'h3281, {o, p[23:16]},
            16'h32A1, f[15:0], 16'h32C1, {o, f[23:16]}, 16'h30A1, 16'h000E, 16'h2000};
    m_q.delete();
    foreach (lst[k]) m_q.push_back(mirror(lst[k]));
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_pos = 0; m_wd = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_pos = 0; m_wd = 0;
          build(mb_addr, fb_addr, boot_op);
        end
      end else if (!cfg_stall) begin
        m_wd = 0;
        if (m_pos == 13) begin m_busy = 0; m_done = 1; end
        else m_pos++;
      end else if (m_wd == 4095) begin
        m_busy = 0;
      end else begin
        m_wd++;
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    string tag;
    check("R1/busy", {15'd0, busy}, {15'd0, m_busy});
    check("R7/valid", {15'd0, cfg_valid}, {15'd0, m_busy});
    check("R10/done", {15'd0, done}, {15'd0, m_done});
    if (m_busy) begin
      if (m_pos inside {3, 5, 7, 9, 11}) tag = "R4 header";
      else if (m_pos inside {4, 6, 8, 10}) tag = "R5 address";
      else tag = "R3 word";
      check(tag, cfg_data, m_q[m_pos]);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    case (stall_mode)
      0: cfg_stall = 1'b0;
      1: cfg_stall = lf[0] & lf[3] | lf[7];
      default: cfg_stall = 1'b1;
    endcase
  endtask

  task automatic wait_idle(input int lim);
    for (int n = 0; n < lim && (m_busy || busy); n++) tick();
  endtask

  initial begin
    int seen_done;
    repeat (3) tick();
    // R1 reset state
    check("R1 reset valid", {15'd0, cfg_valid}, 16'd0);
    check("R1 reset busy", {15'd0, busy}, 16'd0);
    rst = 1'b0;
    tick();

    // Run A: no stall
    mb_addr = 24'h000001; fb_addr = 24'hC0FFEE; boot_op = 8'h0B;
    start = 1'b1; tick(); start = 1'b0;
    check("R2 first valid", {15'd0, cfg_valid}, 16'd1);
    check("R2 first word", cfg_data, 16'hFFFF);
    tick(); tick(); tick();
    check("R6 mirrored header", cfg_data, 16'h4C86);
    tick();
    check("R5 prim low mirrored", cfg_data, 16'h0080);
    tick(); tick();
    check("R5 prim high", cfg_data, mirror({8'h0B, 8'h00}));
    wait_idle(100);
    tick();

    // Run B: random stall, input churn, start while busy
    stall_mode = 1;
    mb_addr = 24'h5A3C81; fb_addr = 24'h0F1E2D; boot_op = 8'h03;
    start = 1'b1; tick(); start = 1'b0;
    mb_addr = 24'hFFFFFF; fb_addr = 24'h000000; boot_op = 8'hEE; // R8 churn
    for (int n = 0; n < 12; n++) begin
      start = (n % 3 == 0); // R9 ignored starts
      tick();
    end
    start = 1'b0;
    wait_idle(400);
    tick();

    // Run C: stall forever, watchdog R11
    stall_mode = 2;
    seen_done = 0;
    start = 1'b1; tick(); start = 1'b0;
    for (int n = 0; n < 4200; n++) begin
      tick();
      if (done) seen_done++;
    end
    check("R11 aborted idle", {15'd0, busy}, 16'd0);
    check("R11 no done", seen_done[15:0], 16'd0);

    // Run D: recovers after abort
    stall_mode = 1;
    mb_addr = 24'h123456; fb_addr = 24'h654321; boot_op = 8'h0B;
    start = 1'b1; tick(); start = 1'b0;
    check("R2 relaunch", {15'd0, busy}, 16'd1);
    wait_idle(400);
    tick(); tick();

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule